// File: doc/BRIEF.md
# Boot Address Remap Decoder

The decoder sits on an AHB-style address path in front of the memory controllers. It looks at every transfer request. Requests that fall into the lowest 256 MByte of the address space, the "zero window", are handled according to a 2-bit strap/control input. The decoder can leave the window on the boot ROM. It can redirect the window onto the SDRAM region or onto the asynchronous RAM/ROM/flash region. It can also trap it with a bus error. This lets a processor fetch its exception table from address zero after boot, whichever memory holds that table.

Each accepted request produces a registered forward strobe in the following cycle. Alongside the strobe come the translated address and a one-hot region select, which the downstream controllers consume. In trap mode a window access is not forwarded. Instead, the decoder answers with the two-cycle AHB error response. The strap value is captured while reset is held and frozen once reset is released.

Top module: `boot_remap_decoder`

## Requirements
- R1: An address is in the zero window when its bits [31:28] are all zero. An accepted request outside the window is forwarded with its address unchanged and region select 3'b000.
- R2: With mode code 2'b00, a window access is forwarded unchanged with region select 3'b001 (boot ROM, bit 0).
- R3: With mode code 2'b01, a window access is forwarded to address 0x2000_0000 plus bits [27:0] of the request, with region select 3'b010 (SDRAM, bit 1).
- R4: With mode code 2'b10, a window access is forwarded to address 0x3000_0000 plus bits [27:0] of the request, with region select 3'b100 (asynchronous memory, bit 2).
- R5: With mode code 2'b11, a window access is not forwarded: fwd_valid_o stays low and region select stays 3'b000. Instead it raises the error response.
- R6: The error response holds hresp_o high for two cycles. hready_o is low in the first of these cycles and high in the second. A new request may be accepted in the second cycle.
- R7: A request presented while hready_o is low is ignored. It produces no forward strobe and no new error response.
- R8: The mode code is sampled on every clock edge while rst_n is low. Changes on remap_sel_i while rst_n is high have no effect on the mapping.
- R9: In the cycle after a reset edge, hready_o is 1, and hresp_o, fwd_valid_o and region_o are 0.
- R10: A request accepted at a clock edge (req_i and hready_o both high) drives fwd_valid_o, fwd_addr_o and region_o after that same edge. With no accepted request, fwd_valid_o is 0 and region_o is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode strap is sampled while it is low |
| remap_sel_i | input | 2 | Mode strap: 00 ROM, 01 SDRAM, 10 asynchronous memory, 11 trap |
| req_i | input | 1 | Transfer request valid for addr_i |
| addr_i | input | 32 | Request address |
| hready_o | output | 1 | Ready; low only in the first error cycle |
| hresp_o | output | 1 | Error response, 1 = ERROR |
| fwd_valid_o | output | 1 | Forwarded transfer strobe |
| fwd_addr_o | output | 32 | Translated address, meaningful when fwd_valid_o is 1 |
| region_o | output | 3 | One-hot target: bit 0 ROM, bit 1 SDRAM, bit 2 asynchronous |

## Verification
Every result of this block is due one clock edge after the request is accepted. This covers the forward strobe, the translated address and the region select. It also covers the first cycle of the error response; the second error cycle is due one edge later. The bench drives each request at the falling edge. Its reference model is advanced at the rising edge from the same inputs, and every output is compared 1 ns after that rising edge. A request held through the first error cycle is therefore expected to be taken only at the edge that ends the second one. Changes made to the strap while rst_n is high are checked by showing that the forwarded region does not move.

// File: rtl/boot_remap_pkg.sv
// Package: shared types for the boot address remap decoder.
// Assumes: region select is one-hot with bit 0 ROM, bit 1 SDRAM, bit 2 async.
package boot_remap_pkg;

    typedef enum logic [1:0] {
        MAP_ROM   = 2'b00,
        MAP_SDRAM = 2'b01,
        MAP_ASYNC = 2'b10,
        MAP_TRAP  = 2'b11
    } map_mode_e;

    typedef enum logic [1:0] {
        RSP_OKAY = 2'b00,
        RSP_ERR1 = 2'b01,
        RSP_ERR2 = 2'b10
    } rsp_state_e;

    localparam int REGION_W   = 3;
    localparam int REG_ROM    = 0;
    localparam int REG_SDRAM  = 1;
    localparam int REG_ASYNC  = 2;

endpackage

// File: rtl/remap_mode_latch.sv
// Module: remap_mode_latch
// Captures the mode strap on every clock while reset is held, then freezes it.
// Assumes: synchronous active-low reset; strap is stable around reset release.
module remap_mode_latch
    import boot_remap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    output map_mode_e  mode_o
);

    map_mode_e mode_q;

    // Sample the strap during reset, hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= map_mode_e'(sel_i);
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/remap_xlate.sv
// Module: remap_xlate
// Combinational window check and address translation for one request.
// Assumes: the window covers the addresses whose upper ADDR_W-WIN_BITS bits are zero.
module remap_xlate
    import boot_remap_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                WIN_BITS   = 28,
    parameter logic [ADDR_W-1:0] SDRAM_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ASYNC_BASE = 32'h3000_0000
) (
    input  map_mode_e             mode_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic [ADDR_W-1:0]     xaddr_o,
    output logic [REGION_W-1:0]   region_o,
    output logic                  trap_o
);

    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic              in_win;
    logic [ADDR_W-1:0] offset;

    // Window hit and zero-extended offset within the window.
    always_comb begin
        in_win = (addr_i[ADDR_W-1:WIN_BITS] == {TAG_W{1'b0}});
        offset = {{TAG_W{1'b0}}, addr_i[WIN_BITS-1:0]};
    end

    // Pick target address, region and trap flag from the frozen mode.
    always_comb begin
        xaddr_o  = addr_i;
        region_o = '0;
        trap_o   = 1'b0;
        if (in_win) begin
            unique case (mode_i)
                MAP_ROM: begin
                    region_o[REG_ROM] = 1'b1;
                end
                MAP_SDRAM: begin
                    xaddr_o            = SDRAM_BASE + offset;
                    region_o[REG_SDRAM] = 1'b1;
                end
                MAP_ASYNC: begin
                    xaddr_o            = ASYNC_BASE + offset;
                    region_o[REG_ASYNC] = 1'b1;
                end
                MAP_TRAP: begin
                    trap_o = 1'b1;
                end
                default: begin
                    trap_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/remap_err_fsm.sv
// Module: remap_err_fsm
// Produces the two-cycle error response: ERROR with ready low, then ERROR with ready high.
// Assumes: start_i is only raised for a request accepted while ready is high.
module remap_err_fsm
    import boot_remap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic hready_o,
    output logic hresp_o
);

    rsp_state_e state_q;
    rsp_state_e state_d;

    // Next-state: first error cycle always moves on; otherwise a trap starts a response.
    always_comb begin
        unique case (state_q)
            RSP_ERR1: state_d = RSP_ERR2;
            default:  state_d = start_i ? RSP_ERR1 : RSP_OKAY;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_OKAY;
        end else begin
            state_q <= state_d;
        end
    end

    assign hready_o = (state_q != RSP_ERR1);
    assign hresp_o  = (state_q != RSP_OKAY);

endmodule

// File: rtl/boot_remap_decoder.sv
// Module: boot_remap_decoder (top)
// Accepts requests, remaps the zero window per the frozen strap and registers
// the forwarded address and region select; traps window accesses in mode 11.
// Assumes: a requester holds req_i/addr_i while hready_o is low.
module boot_remap_decoder
    import boot_remap_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                WIN_BITS   = 28,
    parameter logic [ADDR_W-1:0] SDRAM_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ASYNC_BASE = 32'h3000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        remap_sel_i,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hready_o,
    output logic              hresp_o,
    output logic              fwd_valid_o,
    output logic [ADDR_W-1:0] fwd_addr_o,
    output logic [2:0]        region_o
);

    map_mode_e             mode_q;
    logic [ADDR_W-1:0]     xaddr;
    logic [REGION_W-1:0]   xregion;
    logic                  trap;
    logic                  accept;
    logic                  fwd_valid_q;
    logic [ADDR_W-1:0]     fwd_addr_q;
    logic [REGION_W-1:0]   region_q;

    remap_mode_latch u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (remap_sel_i),
        .mode_o (mode_q)
    );

    remap_xlate #(
        .ADDR_W     (ADDR_W),
        .WIN_BITS   (WIN_BITS),
        .SDRAM_BASE (SDRAM_BASE),
        .ASYNC_BASE (ASYNC_BASE)
    ) u_xlate (
        .mode_i   (mode_q),
        .addr_i   (addr_i),
        .xaddr_o  (xaddr),
        .region_o (xregion),
        .trap_o   (trap)
    );

    remap_err_fsm u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept && trap),
        .hready_o (hready_o),
        .hresp_o  (hresp_o)
    );

    assign accept = req_i && hready_o;

    // Register the forwarded transfer; trapped or absent requests forward nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid_q <= 1'b0;
            fwd_addr_q  <= '0;
            region_q    <= '0;
        end else begin
            fwd_valid_q <= accept && !trap;
            region_q    <= (accept && !trap) ? xregion : '0;
            if (accept) begin
                fwd_addr_q <= xaddr;
            end
        end
    end

    assign fwd_valid_o = fwd_valid_q;
    assign fwd_addr_o  = fwd_addr_q;
    assign region_o    = region_q;

endmodule

// File: rtl/boot_remap_decoder_chk.sv
// Module: boot_remap_decoder_chk
// Assertion checker for the remap decoder, attached by bind.
module boot_remap_decoder_chk
    import boot_remap_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] SDRAM_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ASYNC_BASE = 32'h3000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_q,
    input logic              hready_o,
    input logic              hresp_o,
    input logic              fwd_valid_o,
    input logic [ADDR_W-1:0] fwd_addr_o,
    input logic [2:0]        region_o
);

    // R6: first error cycle is followed by the second with ready high.
    assert_err_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp_o && !hready_o) |=> (hresp_o && hready_o));

    // R6: ready is low only while an error is signalled.
    assert_ready_low_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hready_o |-> hresp_o);

    // R5: nothing is forwarded during the first error cycle.
    assert_no_fwd_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp_o && !hready_o) |-> !fwd_valid_o);

    // R1: region select is never more than one-hot.
    assert_region_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_o));

    // R10: a region is only named for a forwarded transfer.
    assert_region_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (region_o != 3'b000) |-> fwd_valid_o);

    // R3: SDRAM-routed addresses land at or above the SDRAM base.
    assert_sdram_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_o && region_o == 3'b010) |-> (fwd_addr_o >= SDRAM_BASE));

    // R4: async-routed addresses land at or above the async base.
    assert_async_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_o && region_o == 3'b100) |-> (fwd_addr_o >= ASYNC_BASE));

    // R8: the frozen mode does not move while out of reset.
    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

endmodule

bind boot_remap_decoder boot_remap_decoder_chk #(
    .ADDR_W     (ADDR_W),
    .SDRAM_BASE (SDRAM_BASE),
    .ASYNC_BASE (ASYNC_BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .hready_o    (hready_o),
    .hresp_o     (hresp_o),
    .fwd_valid_o (fwd_valid_o),
    .fwd_addr_o  (fwd_addr_o),
    .region_o    (region_o)
);

// File: tb/boot_remap_decoder_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model advanced every rising edge, compared 1 ns later.
module boot_remap_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  remap_sel_i = 2'b00;
    logic        req_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        hready_o, hresp_o, fwd_valid_o;
    logic [31:0] fwd_addr_o;
    logic [2:0]  region_o;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Model state
    int          m_mode = 0;
    int          m_phase = 0;   // 0 idle, 1 first error cycle, 2 second error cycle
    logic        e_valid = 0;
    logic [31:0] e_addr = '0;
    logic [2:0]  e_region = '0;
    string       e_tag = "R9";

    always #2.5 clk = ~clk;

    boot_remap_decoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .remap_sel_i (remap_sel_i),
        .req_i       (req_i),
        .addr_i      (addr_i),
        .hready_o    (hready_o),
        .hresp_o     (hresp_o),
        .fwd_valid_o (fwd_valid_o),
        .fwd_addr_o  (fwd_addr_o),
        .region_o    (region_o)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string rsp_tag);
        chk(rsp_tag, "hready", {31'b0, hready_o}, {31'b0, m_phase != 1});
        chk(rsp_tag, "hresp",  {31'b0, hresp_o},  {31'b0, m_phase != 0});
        chk(e_tag, "fwd_valid", {31'b0, fwd_valid_o}, {31'b0, e_valid});
        chk(e_tag, "region", {29'b0, region_o}, {29'b0, e_region});
        if (e_valid) chk(e_tag, "fwd_addr", fwd_addr_o, e_addr);
    endtask

    task automatic do_reset(logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0;
        req_i = 1'b0;
        remap_sel_i = sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_mode = sel;
        m_phase = 0;
        e_valid = 0;
        e_region = '0;
        e_tag = "R9";
        #1;
        compare_all("R9");
    endtask

    // One cycle: drive at falling edge, update model at rising edge, compare 1 ns later.
    task automatic step(logic req, logic [31:0] addr, string note);
        bit acc;
        @(negedge clk);
        req_i = req;
        addr_i = addr;
        @(posedge clk);
        acc = req && (m_phase != 1);
        e_valid = 0;
        e_region = '0;
        if (!acc) begin
            e_tag = req ? "R7" : "R10";
        end else if (addr >= 32'h1000_0000) begin
            e_valid = 1; e_addr = addr; e_tag = "R1";
        end else if (m_mode == 0) begin
            e_valid = 1; e_addr = addr; e_region = 3'b001; e_tag = "R2";
        end else if (m_mode == 1) begin
            e_valid = 1; e_addr = 32'h2000_0000 + addr; e_region = 3'b010; e_tag = "R3";
        end else if (m_mode == 2) begin
            e_valid = 1; e_addr = 32'h3000_0000 + addr; e_region = 3'b100; e_tag = "R4";
        end else begin
            e_tag = "R5";
        end
        if (note != "") e_tag = note;
        if (m_phase == 1) m_phase = 2;
        else if (acc && addr < 32'h1000_0000 && m_mode == 3) m_phase = 1;
        else m_phase = 0;
        #1;
        compare_all("R6");
    endtask

    initial begin
        do_reset(2'b00);
        step(1, 32'h0000_0000, "");
        step(1, 32'h0123_4560, "");
        step(1, 32'h0FFF_FFFC, "");
        step(1, 32'h1000_0000, "R1");
        step(0, 32'h0000_0040, "R10");
        remap_sel_i = 2'b01;
        step(1, 32'h0000_0100, "R8");
        remap_sel_i = 2'b11;
        step(1, 32'h0000_0000, "R8");

        do_reset(2'b01);
        step(1, 32'h0000_0000, "");
        step(1, 32'h0ABC_DEF0, "");
        step(1, 32'h8000_0004, "");
        step(1, 32'h0FFF_FFFF, "");

        do_reset(2'b10);
        step(1, 32'h0000_0000, "");
        step(1, 32'h0765_4320, "");
        step(0, 32'h0000_0000, "");
        step(1, 32'hF000_0000, "");

        do_reset(2'b11);
        step(1, 32'h0000_0000, "R5");
        step(1, 32'h0000_0000, "R7");
        step(1, 32'h0000_0000, "R6");
        step(1, 32'h2000_0000, "R7");
        step(1, 32'h2000_0000, "R1");
        step(0, 32'h0000_0000, "");
        step(1, 32'h0400_0000, "R5");
        step(0, 32'h0000_0000, "R6");
        step(0, 32'h0000_0000, "R6");
        remap_sel_i = 2'b00;
        step(1, 32'h0000_0010, "R8");

        do_reset(2'b01);
        step(1, 32'h0000_0008, "R8");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule